// File: doc/BRIEF.md
# I2C-Controlled Two-Channel Bus Selector

This block is an I2C target with a single one-byte control register. Its value selects which of two downstream bus channels, if any, is connected. It samples SCL and SDA with the system clock and detects START and STOP conditions. It matches a fixed 7-bit address and shifts data bytes in and out. It acknowledges by pulling SDA low through an open-drain pull request. It then drives two channel-enable outputs toward the switch fabric.

Software writes the register to choose a channel and reads it back to check the selection. A new selection is not passed to the enables at once. An "active" copy of the low three bits loads only when a STOP is seen, so a channel joins the bus only while every line is idle high.

Top module: `i2c_chan_sel`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits are 1110000. Byte bit 0 picks the direction: 0 selects a write and 1 selects a read.
- R2: An address byte with any other upper seven bits is not acknowledged. The data bytes that follow in that transaction are not acknowledged, do not change the register and do not change the enables.
- R3: During a write, every data byte is acknowledged by holding SDA low through the ninth clock. It is stored in the register, so after several bytes the last one is kept.
- R4: A read returns the register, MSB first. SDA is released for the master's acknowledge bit. A master ACK (SDA low) makes the target send the register again. A master NACK (SDA high) ends the read and leaves SDA released.
- R5: The channel code is register bits 2..0. Bit 2 is the enable bit. Code 100 drives chan_en_o = 01 (channel 0). Code 101 drives chan_en_o = 10 (channel 1). Codes 0xx and 11x drive 00. Bits 7..3 have no effect.
- R6: The enables change only in the clock after a STOP is detected. A repeated START does not apply a pending selection.
- R7: After reset the register reads 0x00, both enables are low and SDA is released.
- R8: At most one channel enable is high at any time.
- R9: A START seen in any state, including a repeated START after an unmatched address, restarts address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_pull_o | output | 1 | 1 requests the open-drain SDA driver to pull low |
| chan_en_o | output | 2 | One enable per downstream channel |

## Verification
The same STOP edge must do two things in one clock. It must return the target's bus state to idle, and it must move the pending code into the active register that drives the enables. The bench provokes this after each write of a sweep of control values. It checks that the enables still hold the previous selection once the data byte has been acknowledged, and that they show the decoded new selection a few clocks after STOP. Repeated-START transactions then check that the target restarts address reception while the activation is still held back.

// File: rtl/i2c_sel_pkg.sv
package i2c_sel_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDAT, S_WACK, S_RDAT, S_RACK, S_SKIP
  } tgt_state_t;
endpackage

// File: rtl/bus_cond_det.sv
module bus_cond_det #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC-1:0] scl_ff, sda_ff;
  logic scl_prev, sda_prev;
  logic scl_now, sda_now;

  assign scl_now = scl_ff[SYNC-1];
  assign sda_now = sda_ff[SYNC-1];

  // Lines idle high, so the chain and the history reset to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff   <= '1;
      sda_ff   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_ff   <= {scl_ff[SYNC-2:0], scl_i};
      sda_ff   <= {sda_ff[SYNC-2:0], sda_i};
      scl_prev <= scl_now;
      sda_prev <= sda_now;
    end
  end

  assign sda_o   = sda_now;
  assign start_o = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_o  = scl_now & scl_prev & ~sda_prev & sda_now;
  assign rise_o  = scl_now & ~scl_prev;
  assign fall_o  = ~scl_now & scl_prev;
endmodule

// File: rtl/sel_target_fsm.sv
module sel_target_fsm
  import i2c_sel_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          AW       = 7,
  parameter logic [6:0]  TGT_ADDR = 7'b1110000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic          rise,
  input  logic          fall,
  input  logic          sda,
  output logic [DW-1:0] ctrl_o,
  output logic          pull_o,
  output tgt_state_t    state_o
);
  localparam int CW = $clog2(DW);

  tgt_state_t    st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [DW-1:0] sh, sh_n, ctrl, ctrl_n;
  logic          done, done_n, rw, rw_n, mnack, mnack_n, pull, pull_n;

  always_comb begin
    st_n = st; cnt_n = cnt; sh_n = sh; ctrl_n = ctrl;
    done_n = done; rw_n = rw; mnack_n = mnack; pull_n = pull;
    if (start) begin
      st_n = S_ADDR; cnt_n = '0; done_n = 1'b0; pull_n = 1'b0;
    end else if (stop) begin
      st_n = S_IDLE; done_n = 1'b0; pull_n = 1'b0;
    end else begin
      case (st)
        S_ADDR, S_WDAT: begin
          if (rise) begin
            sh_n  = {sh[DW-2:0], sda};
            cnt_n = cnt + 1'b1;
            if (cnt == CW'(DW-1)) done_n = 1'b1;
          end else if (fall && done) begin
            done_n = 1'b0;
            cnt_n  = '0;
            if (st == S_ADDR) begin
              if (sh[DW-1 -: AW] == TGT_ADDR) begin
                st_n = S_AACK; pull_n = 1'b1; rw_n = sh[0];
              end else begin
                st_n = S_SKIP;
              end
            end else begin
              ctrl_n = sh; pull_n = 1'b1; st_n = S_WACK;
            end
          end
        end
        S_AACK: if (fall) begin
          cnt_n = '0;
          if (rw) begin
            st_n = S_RDAT; sh_n = ctrl; pull_n = ~ctrl[DW-1];
          end else begin
            st_n = S_WDAT; pull_n = 1'b0;
          end
        end
        S_WACK: if (fall) begin
          st_n = S_WDAT; pull_n = 1'b0; cnt_n = '0;
        end
        S_RDAT: if (fall) begin
          cnt_n = cnt + 1'b1;
          if (cnt == CW'(DW-1)) begin
            st_n = S_RACK; pull_n = 1'b0;
          end else begin
            sh_n = {sh[DW-2:0], 1'b0}; pull_n = ~sh[DW-2];
          end
        end
        S_RACK: begin
          if (rise) mnack_n = sda;
          else if (fall) begin
            if (mnack) st_n = S_SKIP;
            else begin
              st_n = S_RDAT; sh_n = ctrl; pull_n = ~ctrl[DW-1]; cnt_n = '0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; ctrl <= '0;
      done <= 1'b0; rw <= 1'b0; mnack <= 1'b0; pull <= 1'b0;
    end else begin
      st <= st_n; cnt <= cnt_n; sh <= sh_n; ctrl <= ctrl_n;
      done <= done_n; rw <= rw_n; mnack <= mnack_n; pull <= pull_n;
    end
  end

  assign ctrl_o  = ctrl;
  assign pull_o  = pull;
  assign state_o = st;
endmodule

// File: rtl/chan_decode.sv
module chan_decode #(
  parameter int NCH  = 2,
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stop,
  input  logic [SELW:0]   code_i,
  output logic [NCH-1:0]  en_o
);
  logic [SELW:0] act, act_n;

  always_comb begin
    act_n = act;
    if (stop) act_n = code_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act <= '0;
    else        act <= act_n;
  end

  // Codes at or above NCH select nothing.
  for (genvar i = 0; i < NCH; i++) begin : g_en
    assign en_o[i] = act[SELW] & (act[SELW-1:0] == SELW'(i));
  end
endmodule

// File: rtl/i2c_chan_sel.sv
module i2c_chan_sel
  import i2c_sel_pkg::*;
#(
  parameter int         NCH      = 2,
  parameter int         SELW     = 2,
  parameter int         DW       = 8,
  parameter int         SYNC     = 2,
  parameter logic [6:0] TGT_ADDR = 7'b1110000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scl_i,
  input  logic           sda_i,
  output logic           sda_pull_o,
  output logic [NCH-1:0] chan_en_o
);
  logic [1:0]    rst_q;
  logic          rst_int;
  logic          sda_s, start_w, stop_w, rise_w, fall_w;
  logic [DW-1:0] ctrl_w;
  tgt_state_t    fsm_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int = rst_q[1];

  bus_cond_det #(.SYNC(SYNC)) u_det (
    .clk(clk), .rst_n(rst_int), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_s), .start_o(start_w), .stop_o(stop_w),
    .rise_o(rise_w), .fall_o(fall_w)
  );

  sel_target_fsm #(.DW(DW), .AW(7), .TGT_ADDR(TGT_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_int), .start(start_w), .stop(stop_w),
    .rise(rise_w), .fall(fall_w), .sda(sda_s),
    .ctrl_o(ctrl_w), .pull_o(sda_pull_o), .state_o(fsm_st)
  );

  chan_decode #(.NCH(NCH), .SELW(SELW)) u_dec (
    .clk(clk), .rst_n(rst_int), .stop(stop_w),
    .code_i(ctrl_w[SELW:0]), .en_o(chan_en_o)
  );
endmodule

// File: rtl/sel_chk.sv
module sel_chk
  import i2c_sel_pkg::*;
#(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           scl_s,
  input logic           stop,
  input tgt_state_t     state,
  input logic           sda_pull_o,
  input logic [NCH-1:0] chan_en_o
);
  p_onehot_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_en_o));

  p_en_only_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !stop |=> $stable(chan_en_o));

  p_skip_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SKIP) |-> !sda_pull_o);

  p_pull_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_s);

  p_reset_idle_r7: assert property (@(posedge clk)
    $rose(rst_n) |-> (chan_en_o == '0) && !sda_pull_o);
endmodule

bind i2c_chan_sel sel_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(u_det.scl_now), .stop(stop_w),
  .state(fsm_st), .sda_pull_o(sda_pull_o), .chan_en_o(chan_en_o)
);

// File: tb/sim_i2c_chan_sel.sv
module sim_i2c_chan_sel;
  localparam int Q = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic pull;
  logic [1:0] en;
  wire sda_line = sda_m & ~pull;
  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  i2c_chan_sel u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(pull), .chan_en_o(en)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_en(input logic [7:0] v);
    if (!v[2])            return 2'b00;
    if (v[1:0] == 2'b00)  return 2'b01;
    if (v[1:0] == 2'b01)  return 2'b10;
    return 2'b00;
  endfunction

  task automatic hp(); repeat (Q) @(negedge clk); endtask
  task automatic gap(); repeat (2) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; gap();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; gap();
    end
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); ack = ~sda_line; scl_m = 1'b0; gap();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp(); scl_m = 1'b1; hp(); d[i] = sda_line; scl_m = 1'b0; gap();
    end
    sda_m = ~mack; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; gap(); sda_m = 1'b1;
  endtask

  task automatic read_reg(output logic [7:0] d);
    logic a;
    bus_start(); send_byte(8'hE1, a);
    check("R1 read address ack", a, 1);
    recv_byte(1'b0, d); bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d, d2, v, prev;
    repeat (5) @(negedge clk);
    check("R7 enables after reset", en, 0);
    check("R7 SDA released after reset", pull, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    read_reg(d);
    check("R7 register reads zero", d, 0);
    check("R4 SDA released after NACK", pull, 0);
    prev = 8'h00;

    // Sweep of control values: deferred activation and decode.
    for (int k = 0; k < 32; k++) begin
      v = {5'(k * 7), 3'(k)};
      bus_start(); send_byte(8'hE0, a);
      check("R1 write address ack", a, 1);
      send_byte(v, a);
      check("R3 data byte ack", a, 1);
      check("R6 enables held before STOP", en, exp_en(prev));
      bus_stop(); repeat (6) @(negedge clk);
      check("R5 decoded enables after STOP", en, exp_en(v));
      read_reg(d);
      check("R4 read returns register", d, v);
      prev = v;
    end

    // Multi-byte write keeps the last byte.
    bus_start(); send_byte(8'hE0, a);
    send_byte(8'h04, a); send_byte(8'hA6, a); send_byte(8'hF5, a);
    check("R3 last byte acked", a, 1);
    bus_stop(); repeat (6) @(negedge clk);
    check("R3 enables from last byte", en, 2'b10);

    // Read with master ACK repeats the register.
    bus_start(); send_byte(8'hE1, a);
    recv_byte(1'b1, d); recv_byte(1'b0, d2); bus_stop();
    check("R4 first read byte", d, 8'hF5);
    check("R4 repeat after master ACK", d2, 8'hF5);

    // Unmatched addresses.
    bus_start(); send_byte(8'hE2, a);
    check("R2 no ack on address 1110001", a, 0);
    send_byte(8'h04, a);
    check("R2 no ack on ignored data", a, 0);
    bus_stop(); repeat (6) @(negedge clk);
    check("R2 enables unchanged", en, 2'b10);
    bus_start(); send_byte(8'h60, a);
    check("R2 no ack on address 0110000", a, 0);
    bus_stop();
    read_reg(d);
    check("R2 register unchanged", d, 8'hF5);

    // Repeated START holds the pending selection.
    bus_start(); send_byte(8'hE0, a); send_byte(8'h04, a);
    bus_start(); send_byte(8'hE1, a);
    check("R9 address after repeated START", a, 1);
    recv_byte(1'b0, d);
    check("R6 register visible before STOP", d, 8'h04);
    check("R6 no activation on repeated START", en, 2'b10);
    bus_stop(); repeat (6) @(negedge clk);
    check("R6 activation at STOP", en, 2'b01);

    // Repeated START after an unmatched address.
    bus_start(); send_byte(8'hE4, a);
    bus_start(); send_byte(8'hE0, a);
    check("R9 restart after unmatched address", a, 1);
    send_byte(8'h0E, a); bus_stop(); repeat (6) @(negedge clk);
    check("R5 code 110 selects none", en, 2'b00);
    check("R8 no enable for code 11x", en, 2'b00);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule